// File: doc/BRIEF.md
# HDLC Receive FIFO with Latched Event Status

This block sits behind an HDLC receive deframer. The deframer has already found the flags, removed the stuffed bits and checked the CRC. It hands over bytes one at a time, together with single-cycle indications: packet start, good packet end, CRC error and abort. Each accepted byte is stored in a 64-entry FIFO with a one-bit tag. The tag marks the first byte of a message, so a reader draining the FIFO can find message boundaries.

Besides the FIFO, the block keeps an event register for a CPU. Six sticky event bits are kept in this register:

- overrun;
- opening byte at the read head;
- packet end;
- packet start;
- fill above a programmable high watermark;
- FIFO not empty.

Level conditions such as not-empty and above-watermark set their bits only on a rising edge. A read of the register clears it. A per-bit mask selects which latched events drive a single interrupt line.

When a byte arrives and the FIFO is full, the packet being received is cut off. The block drops all later bytes until the deframer reports the next packet start.

Top module: `hdlc_rx_evt_fifo`

## Requirements
- R1: The FIFO keeps up to DEPTH (default 64) bytes in arrival order. `fill_level` shows the count, and `pop_data`/`pop_first` show the head entry. A `pop` removes the head entry, and a `pop` while empty changes nothing.
- R2: A byte offered while the FIFO is full is not stored, even if `pop` is high in the same cycle. It sets the overrun bit (bit 5), and later bytes are dropped without a new overrun until `in_start` is seen. A byte that comes with `in_start` is admitted.
- R3: The opening-byte bit (bit 4) sets whenever the head of the FIFO becomes a byte tagged as first. This happens either when such a byte is written into an empty FIFO or when a pop exposes it. An untagged head sets nothing.
- R4: The packet-end bit (bit 3) sets on `in_end_ok`, `in_crc_err`, `in_abort`, or an overrun.
- R5: The packet-start bit (bit 2) sets on `in_start`.
- R6: The high-watermark bit (bit 1) sets when `fill_level > hwm_level` goes from false to true.
- R7: The not-empty bit (bit 0) sets when `fill_level` goes from 0 to non-zero.
- R8: All bits reset to 0. Each set bit stays set until a cycle with `stat_rd` high, after which the register reads 0. Bits 7 and 6 always read 0.
- R9: An event that arrives in the same cycle as `stat_rd` is set in the register after that read.
- R10: `irq` is high exactly when some bit of `stat_data[5:0] & irq_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is offered this cycle |
| in_data | input | 8 | Received byte |
| in_first | input | 1 | Offered byte is the first byte of a message |
| in_start | input | 1 | Deframer found an opening flag (packet start) |
| in_end_ok | input | 1 | Message ended with a good CRC |
| in_crc_err | input | 1 | Message ended with a CRC error |
| in_abort | input | 1 | Abort sequence received |
| pop | input | 1 | Remove the head byte |
| pop_data | output | 8 | Head byte |
| pop_first | output | 1 | Head byte is tagged as first of a message |
| fill_level | output | 7 | Number of stored bytes |
| hwm_level | input | 6 | High watermark; the level is above it when fill_level exceeds it |
| stat_rd | input | 1 | Register read strobe; clears the register at this edge |
| stat_data | output | 8 | Latched event bits |
| irq_mask | input | 6 | Per-bit interrupt enables for bits 5..0 |
| irq | output | 1 | Interrupt request |

## Verification
The deframer indications (start, end, CRC error, abort) and overrun appear in `stat_data` one clock edge after the cycle in which they are driven. Events derived from a level depend on that level having been updated first: not-empty, above-watermark and opening byte appear one edge after the edge that changed `fill_level` or the head. This makes them due two edges after a push or pop stimulus.

The bench drives every input 1 ns after a rising edge. It then steps exactly one edge for the direct indications, and two edges for the level events, before sampling 1 ns past the edge. Reads are checked by comparing the register just after the clearing edge. `irq` is combinational from the register and the mask, so the bench checks it within the same cycle in which the mask is changed.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

    typedef struct packed {
        logic       first;
        logic [7:0] data;
    } hrf_entry_t;

    // Field order sets the bit positions: ovr is bit 5, ne is bit 0.
    typedef struct packed {
        logic ovr;
        logic obyte;
        logic pend;
        logic pstart;
        logic hwm;
        logic ne;
    } hrf_evt_t;

    localparam int EVT_W  = $bits(hrf_evt_t);
    localparam int STAT_W = 8;

    function automatic logic [STAT_W-1:0] hrf_pack(input hrf_evt_t e);
        return {{(STAT_W-EVT_W){1'b0}}, e};
    endfunction

endpackage

// File: rtl/hrf_store.sv
module hrf_store
    import hrf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  hrf_entry_t    wr_entry,
    input  logic          pop,
    output hrf_entry_t    head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          popped
);

    hrf_entry_t    mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign popped  = pop && (cnt_q != '0);
    assign head    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wrap_inc(wp_q);
            if (popped)  rp_q <= wrap_inc(rp_q);
            case ({do_push, popped})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/hrf_admit.sv
module hrf_admit (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_start,
    input  logic full,
    output logic push,
    output logic overrun
);

    logic drop_q;
    logic take;

    // A packet start reopens admission in the same cycle.
    assign take    = in_valid && (!drop_q || in_start);
    assign push    = take && !full;
    assign overrun = take && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_q <= 1'b0;
        end else if (overrun) begin
            drop_q <= 1'b1;
        end else if (in_start) begin
            drop_q <= 1'b0;
        end
    end

endmodule

// File: rtl/hrf_events.sv
module hrf_events
    import hrf_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     count,
    input  logic [CW-1:0]     thresh,
    input  logic              head_first,
    input  logic              popped,
    input  logic              overrun,
    input  logic              end_ok,
    input  logic              crc_err,
    input  logic              abort,
    input  logic              start,
    input  logic              stat_rd,
    input  logic [EVT_W-1:0]  irq_mask,
    output logic [STAT_W-1:0] stat_data,
    output logic              irq
);

    hrf_evt_t stat_q, evt;
    logic     ne_lvl, hwm_lvl, open_lvl;
    logic     ne_q, hwm_q, open_q, popped_q;

    assign ne_lvl   = (count != '0);
    assign hwm_lvl  = (count > thresh);
    assign open_lvl = ne_lvl && head_first;

    always_comb begin
        evt        = '0;
        evt.ovr    = overrun;
        evt.pend   = overrun || end_ok || crc_err || abort;
        evt.pstart = start;
        evt.ne     = ne_lvl && !ne_q;
        evt.hwm    = hwm_lvl && !hwm_q;
        evt.obyte  = open_lvl && (!open_q || popped_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q   <= '0;
            ne_q     <= 1'b0;
            hwm_q    <= 1'b0;
            open_q   <= 1'b0;
            popped_q <= 1'b0;
        end else begin
            stat_q   <= (stat_rd ? hrf_evt_t'('0) : stat_q) | evt;
            ne_q     <= ne_lvl;
            hwm_q    <= hwm_lvl;
            open_q   <= open_lvl;
            popped_q <= popped;
        end
    end

    assign stat_data = hrf_pack(stat_q);
    assign irq       = |(stat_q & irq_mask);

endmodule

// File: rtl/hdlc_rx_evt_fifo.sv
module hdlc_rx_evt_fifo
    import hrf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_first,
    input  logic              in_start,
    input  logic              in_end_ok,
    input  logic              in_crc_err,
    input  logic              in_abort,
    input  logic              pop,
    output logic [7:0]        pop_data,
    output logic              pop_first,
    output logic [CW-1:0]     fill_level,
    input  logic [AW-1:0]     hwm_level,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_data,
    input  logic [EVT_W-1:0]  irq_mask,
    output logic              irq
);

    hrf_entry_t    wr_entry, head;
    logic          st_full, st_popped;
    logic          adm_push, adm_overrun;
    logic [CW-1:0] thresh;

    assign wr_entry.first = in_first;
    assign wr_entry.data  = in_data;
    assign thresh         = CW'(hwm_level);

    hrf_admit u_admit (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_start (in_start),
        .full     (st_full),
        .push     (adm_push),
        .overrun  (adm_overrun)
    );

    hrf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (adm_push),
        .wr_entry (wr_entry),
        .pop      (pop),
        .head     (head),
        .count    (fill_level),
        .full     (st_full),
        .popped   (st_popped)
    );

    hrf_events #(.CW(CW)) u_events (
        .clk        (clk),
        .rst        (rst),
        .count      (fill_level),
        .thresh     (thresh),
        .head_first (head.first),
        .popped     (st_popped),
        .overrun    (adm_overrun),
        .end_ok     (in_end_ok),
        .crc_err    (in_crc_err),
        .abort      (in_abort),
        .start      (in_start),
        .stat_rd    (stat_rd),
        .irq_mask   (irq_mask),
        .stat_data  (stat_data),
        .irq        (irq)
    );

    assign pop_data  = head.data;
    assign pop_first = head.first;

endmodule

// File: rtl/hrf_checker.sv
module hrf_checker #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_start,
    input logic          in_end_ok,
    input logic          in_crc_err,
    input logic          in_abort,
    input logic          pop,
    input logic          stat_rd,
    input logic [7:0]    stat_data,
    input logic [5:0]    irq_mask,
    input logic          irq,
    input logic [CW-1:0] fill_level,
    input logic          overrun_p
);

    p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
        fill_level <= CW'(DEPTH));

    p_full_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (fill_level == CW'(DEPTH) && !pop) |=> fill_level == CW'(DEPTH));

    p_overrun_flag_r2: assert property (@(posedge clk) disable iff (rst)
        overrun_p |=> (stat_data[5] && stat_data[3]));

    p_end_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (in_end_ok || in_crc_err || in_abort) |=> stat_data[3]);

    p_start_flag_r5: assert property (@(posedge clk) disable iff (rst)
        in_start |=> stat_data[2]);

    p_ne_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_level != '0 && $past(fill_level) == '0) |=> stat_data[0]);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((stat_data & $past(stat_data)) == $past(stat_data)));

    p_top_zero_r8: assert property (@(posedge clk) disable iff (rst)
        stat_data[7:6] == 2'b00);

    p_read_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && in_start) |=> stat_data[2]);

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '0) |-> !irq);

endmodule

bind hdlc_rx_evt_fifo hrf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_start   (in_start),
    .in_end_ok  (in_end_ok),
    .in_crc_err (in_crc_err),
    .in_abort   (in_abort),
    .pop        (pop),
    .stat_rd    (stat_rd),
    .stat_data  (stat_data),
    .irq_mask   (irq_mask),
    .irq        (irq),
    .fill_level (fill_level),
    .overrun_p  (adm_overrun)
);

// File: tb/hdlc_rx_evt_fifo_bench.sv
`timescale 1ns/1ps
module hdlc_rx_evt_fifo_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_first, in_start, in_end_ok, in_crc_err, in_abort;
    logic [7:0] in_data;
    logic       pop;
    logic [7:0] pop_data;
    logic       pop_first;
    logic [6:0] fill_level;
    logic [5:0] hwm_level;
    logic       stat_rd;
    logic [7:0] stat_data;
    logic [5:0] irq_mask;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hdlc_rx_evt_fifo u_hdlc_rx_evt_fifo (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_start(in_start), .in_end_ok(in_end_ok),
        .in_crc_err(in_crc_err), .in_abort(in_abort), .pop(pop),
        .pop_data(pop_data), .pop_first(pop_first), .fill_level(fill_level),
        .hwm_level(hwm_level), .stat_rd(stat_rd), .stat_data(stat_data),
        .irq_mask(irq_mask), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push1(input logic [7:0] d, input logic f);
        in_valid = 1'b1; in_data = d; in_first = f;
        tick();
        in_valid = 1'b0; in_first = 1'b0;
    endtask

    task automatic pop1(output logic [7:0] d, output logic f);
        d = pop_data; f = pop_first;
        pop = 1'b1;
        tick();
        pop = 1'b0;
    endtask

    task automatic read_stat(output logic [7:0] v);
        v = stat_data;
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
    endtask

    task automatic pulse_start();
        in_start = 1'b1; tick(); in_start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 reset stat", stat_data, 0);
        chk("R1 reset fill", fill_level, 0);
        chk("R10 reset irq", irq, 0);
    endtask

    task automatic t_order();
        logic [7:0] d, v;
        logic       f;
        push1(8'hA1, 1'b1);
        push1(8'hB2, 1'b0);
        push1(8'hC3, 1'b0);
        tick();
        chk("R1 fill after 3 pushes", fill_level, 3);
        chk("R7 R3 ne and opening byte", stat_data, 8'h11);
        read_stat(v);
        chk("R8 cleared by read", stat_data, 0);
        pop1(d, f); chk("R1 order byte0", {f, d}, {1'b1, 8'hA1});
        pop1(d, f); chk("R1 order byte1", {f, d}, {1'b0, 8'hB2});
        pop1(d, f); chk("R1 order byte2", {f, d}, {1'b0, 8'hC3});
        chk("R1 fill after drain", fill_level, 0);
        pop1(d, f);
        tick();
        chk("R1 pop on empty", fill_level, 0);
        chk("R3 untagged head sets nothing", stat_data, 0);
    endtask

    task automatic t_obyte_pop();
        logic [7:0] d, v;
        logic       f;
        push1(8'h10, 1'b1);
        push1(8'h11, 1'b0);
        push1(8'h12, 1'b1);
        tick();
        read_stat(v);
        pop1(d, f); tick();
        chk("R3 untagged head after pop", stat_data, 0);
        pop1(d, f); tick();
        chk("R3 tagged head exposed by pop", stat_data, 8'h10);
        read_stat(v);
        pop1(d, f); tick();
        read_stat(v);
    endtask

    task automatic t_hwm();
        logic [7:0] d, v;
        logic       f;
        hwm_level = 6'd4;
        for (int i = 0; i < 4; i++) push1(8'(i), 1'b0);
        tick();
        read_stat(v);
        chk("R6 no event at watermark", v, 8'h01);
        push1(8'h44, 1'b0);
        tick();
        chk("R6 event above watermark", stat_data, 8'h02);
        for (int i = 0; i < 5; i++) pop1(d, f);
        tick();
        read_stat(v);
        hwm_level = 6'd63;
    endtask

    task automatic t_overrun();
        logic [7:0] d, v;
        logic       f;
        for (int i = 0; i < 64; i++) push1(8'(i), (i == 0));
        tick();
        read_stat(v);
        chk("R1 full count", fill_level, 64);
        push1(8'hEE, 1'b0);
        chk("R2 R4 overrun and packet end", stat_data, 8'h28);
        chk("R2 full byte not stored", fill_level, 64);
        read_stat(v);
        pop1(d, f);
        chk("R2 head before overrun kept", {f, d}, {1'b1, 8'h00});
        tick();
        push1(8'h55, 1'b0);
        tick();
        chk("R2 dropped while discarding", fill_level, 63);
        chk("R2 no repeat overrun", stat_data, 0);
        in_valid = 1'b1; in_start = 1'b1; in_first = 1'b1; in_data = 8'h77;
        tick();
        in_valid = 1'b0; in_start = 1'b0; in_first = 1'b0;
        chk("R2 R5 start reopens admission", stat_data, 8'h04);
        chk("R2 byte with start stored", fill_level, 64);
        for (int i = 0; i < 64; i++) pop1(d, f);
        chk("R2 last byte is the restart byte", {f, d}, {1'b1, 8'h77});
        tick();
        read_stat(v);
    endtask

    task automatic t_ends();
        logic [7:0] v;
        in_end_ok = 1'b1; tick(); in_end_ok = 1'b0;
        chk("R4 good end", stat_data, 8'h08);
        read_stat(v);
        in_crc_err = 1'b1; tick(); in_crc_err = 1'b0;
        chk("R4 crc error end", stat_data, 8'h08);
        read_stat(v);
        in_abort = 1'b1; tick(); in_abort = 1'b0;
        chk("R4 abort end", stat_data, 8'h08);
        read_stat(v);
        pulse_start();
        chk("R5 packet start", stat_data, 8'h04);
        read_stat(v);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        pulse_start();
        stat_rd = 1'b1; in_abort = 1'b1;
        tick();
        stat_rd = 1'b0; in_abort = 1'b0;
        chk("R9 event during read survives", stat_data, 8'h08);
        read_stat(v);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        pulse_start();
        irq_mask = 6'h00; #1;
        chk("R10 masked off", irq, 0);
        irq_mask = 6'h04; #1;
        chk("R10 enabled bit", irq, 1);
        irq_mask = 6'h3B; #1;
        chk("R10 other bits only", irq, 0);
        irq_mask = 6'h04;
        read_stat(v);
        chk("R10 cleared register", irq, 0);
        irq_mask = 6'h00;
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 0; in_data = 0; in_first = 0; in_start = 0;
        in_end_ok = 0; in_crc_err = 0; in_abort = 0; pop = 0;
        stat_rd = 0; irq_mask = 0; hwm_level = 6'd63;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_order();
        t_obyte_pop();
        t_hwm();
        t_overrun();
        t_ends();
        t_collide();
        t_irq();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule